// File: doc/BRIEF.md
# Page Translation Cache

This block keeps a handful of recent virtual-to-physical page translations so that most memory accesses skip the page-table walk. A requester presents a 20-bit virtual page number together with the 12-bit page offset. In the same cycle the block reports whether a translation is held. On a hit it returns the 20-bit physical frame number, the full 32-bit physical address (frame number joined with the unchanged offset), and the page's reference and dirty status.

Every entry is searched in parallel, so any entry can hold any page. After a miss, an outside walker installs the translation through the fill port. A flush input drops every translation at once, for example on an address-space switch. Lookups keep the status bits current: any hit marks the page referenced, and a write hit also marks it dirty. Writing those bits back to the page table is left to the surrounding logic.

Top module: `xlate_cache`

## Requirements
- R1: After reset every entry is invalid, so every lookup misses until a fill has taken effect.
- R2: A lookup that matches a valid entry raises `hit` in the same cycle. It drives `pfn` with the stored frame number and `physAddr` with {frame number, `lkOffset`}, the frame number in the upper 20 bits.
- R3: On a miss, or when `lkValid` is low, `hit`, `pfn`, `physAddr`, `hitRef` and `hitDirty` are all zero.
- R4: `hitRef` and `hitDirty` show the entry's status as it stood before the current lookup. Every hit sets the entry's reference bit from the next cycle on. A fill clears both status bits of the entry it writes.
- R5: A hit with `lkWrite` high sets the entry's dirty bit from the next cycle on. A read hit leaves the dirty bit unchanged.
- R6: A fill whose page is not held goes to the lowest-numbered invalid entry while any entry is invalid, so no valid translation is displaced while room remains.
- R7: When every entry is valid, a fill of a new page replaces the entry named by a round-robin pointer. The pointer starts at entry 0 after reset. It advances by one, wrapping after the last entry, only when it has been used for a replacement.
- R8: A fill whose page is already held rewrites that entry in place and leaves the pointer unchanged, so at most one entry ever matches a page.
- R9: A flush clears every valid bit in one cycle, and lookups miss from the next cycle on. The round-robin pointer keeps its value across a flush.
- R10: When a fill and a flush arrive in the same cycle, the flush wins and the fill is discarded.
- R11: A lookup sees the contents as they were before any fill in the same cycle. If that fill writes the entry that hit, the filled values and cleared status win over the hit's status update.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| lkValid | input | 1 | Lookup request this cycle |
| lkWrite | input | 1 | Lookup is a write access |
| lkVpn | input | 20 | Virtual page number to translate |
| lkOffset | input | 12 | Page offset, passed through to the physical address |
| fillValid | input | 1 | Install a translation this cycle |
| fillVpn | input | 20 | Virtual page number of the translation to install |
| fillPfn | input | 20 | Physical frame number of the translation to install |
| flush | input | 1 | Invalidate all entries |
| hit | output | 1 | Lookup matched a valid entry |
| pfn | output | 20 | Frame number of the matching entry, zero on a miss |
| physAddr | output | 32 | Translated physical address, zero on a miss |
| hitRef | output | 1 | Reference bit of the matching entry before this lookup |
| hitDirty | output | 1 | Dirty bit of the matching entry before this lookup |

## Verification
A damaged valid bit or tag shows up on the very next lookup of that page, as a wrong `hit` in the same cycle. A wrong frame shows at once on `pfn` and `physAddr`. Status bits that are dropped or stuck appear on the second lookup of the same page, one cycle after the access that should have set them. A wrong fill target or pointer stays hidden until a later lookup misses a page that should have survived, or hits a page that should have been evicted. For that reason the sequences run the buffer full more than once, across a flush, and probe both the evicted page and its neighbours.

// File: rtl/xlate_pkg.sv
package xlate_pkg;

  // Strobes sent from the control unit to the entry datapath each cycle
  typedef struct packed {
    logic flushAll;    // drop every translation
    logic fillEn;      // write the entry selected by fillSel
    logic touchEn;     // a lookup hit: update status of the matching entry
    logic touchWrite;  // the hitting lookup was a write
  } xlateStrobe_t;

  // Default geometry of the cache
  localparam int unsigned XC_ENTRIES = 8;
  localparam int unsigned XC_VPN_W   = 20;
  localparam int unsigned XC_PFN_W   = 20;
  localparam int unsigned XC_OFF_W   = 12;

endpackage

// File: rtl/xlate_datapath.sv
module xlate_datapath
  import xlate_pkg::*;
#(
  parameter int unsigned N     = XC_ENTRIES,
  parameter int unsigned VPN_W = XC_VPN_W,
  parameter int unsigned PFN_W = XC_PFN_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  xlateStrobe_t      strobe,
  input  logic [N-1:0]      fillSel,
  input  logic [VPN_W-1:0]  lkVpn,
  input  logic [VPN_W-1:0]  fillVpn,
  input  logic [PFN_W-1:0]  fillPfn,
  output logic [N-1:0]      lkMatch,
  output logic [N-1:0]      fillMatch,
  output logic [N-1:0]      validVec,
  output logic [PFN_W-1:0]  selPfn,
  output logic              selRef,
  output logic              selDirty
);

  logic [VPN_W-1:0] tagQ   [N];
  logic [PFN_W-1:0] frameQ [N];
  logic [N-1:0]     validQ;
  logic [N-1:0]     refQ;
  logic [N-1:0]     dirtyQ;

  for (genvar g = 0; g < N; g++) begin : gEntry
    // Parallel compare of both the lookup page and the fill page
    assign lkMatch[g]   = validQ[g] && (tagQ[g] == lkVpn);
    assign fillMatch[g] = validQ[g] && (tagQ[g] == fillVpn);

    always_ff @(posedge clk) begin
      if (!rstN) begin
        validQ[g] <= 1'b0;
        refQ[g]   <= 1'b0;
        dirtyQ[g] <= 1'b0;
        tagQ[g]   <= '0;
        frameQ[g] <= '0;
      end else if (strobe.flushAll) begin
        validQ[g] <= 1'b0;
      end else begin
        if (strobe.touchEn && lkMatch[g]) begin
          refQ[g] <= 1'b1;
          if (strobe.touchWrite) dirtyQ[g] <= 1'b1;
        end
        // Fill comes last so it overrides a status update on the same entry
        if (strobe.fillEn && fillSel[g]) begin
          validQ[g] <= 1'b1;
          tagQ[g]   <= fillVpn;
          frameQ[g] <= fillPfn;
          refQ[g]   <= 1'b0;
          dirtyQ[g] <= 1'b0;
        end
      end
    end
  end

  assign validVec = validQ;

  // AND-OR read mux; at most one match bit is set
  always_comb begin
    selPfn   = '0;
    selRef   = 1'b0;
    selDirty = 1'b0;
    for (int i = 0; i < N; i++) begin
      selPfn   = selPfn | (frameQ[i] & {PFN_W{lkMatch[i]}});
      selRef   = selRef | (refQ[i] & lkMatch[i]);
      selDirty = selDirty | (dirtyQ[i] & lkMatch[i]);
    end
  end

endmodule

// File: rtl/xlate_ctrl.sv
module xlate_ctrl
  import xlate_pkg::*;
#(
  parameter int unsigned N = XC_ENTRIES
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          lkValid,
  input  logic          lkWrite,
  input  logic          fillValid,
  input  logic          flush,
  input  logic [N-1:0]  lkMatch,
  input  logic [N-1:0]  fillMatch,
  input  logic [N-1:0]  validVec,
  output xlateStrobe_t  strobe,
  output logic [N-1:0]  fillSel,
  output logic          hit
);

  localparam int unsigned IDX_W = (N > 1) ? $clog2(N) : 1;
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(N - 1);

  logic [IDX_W-1:0] rrQ;
  logic [N-1:0]     rrSel;
  logic [N-1:0]     invVec;
  logic [N-1:0]     lowInv;
  logic             anyFillMatch;
  logic             anyInvalid;
  logic             fillAccept;
  logic             useRr;

  assign hit          = lkValid && (|lkMatch);
  assign anyFillMatch = |fillMatch;
  assign invVec       = ~validVec;
  assign anyInvalid   = |invVec;
  // Isolate the lowest set bit of the invalid vector
  assign lowInv       = invVec & (~invVec + {{(N-1){1'b0}}, 1'b1});
  assign fillAccept   = fillValid && !flush;
  assign useRr        = fillAccept && !anyFillMatch && !anyInvalid;

  always_comb begin
    for (int i = 0; i < N; i++) rrSel[i] = (rrQ == IDX_W'(i));
  end

  always_comb begin
    if (anyFillMatch)    fillSel = fillMatch;
    else if (anyInvalid) fillSel = lowInv;
    else                 fillSel = rrSel;
  end

  always_comb begin
    strobe.flushAll   = flush;
    strobe.fillEn     = fillAccept;
    strobe.touchEn    = hit;
    strobe.touchWrite = lkWrite;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rrQ <= '0;
    end else if (useRr) begin
      rrQ <= (rrQ == LAST_IDX) ? '0 : rrQ + 1'b1;
    end
  end

endmodule

// File: rtl/xlate_cache.sv
module xlate_cache
  import xlate_pkg::*;
#(
  parameter int unsigned ENTRIES = XC_ENTRIES,
  parameter int unsigned VPN_W   = XC_VPN_W,
  parameter int unsigned PFN_W   = XC_PFN_W,
  parameter int unsigned OFF_W   = XC_OFF_W
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    lkValid,
  input  logic                    lkWrite,
  input  logic [VPN_W-1:0]        lkVpn,
  input  logic [OFF_W-1:0]        lkOffset,
  input  logic                    fillValid,
  input  logic [VPN_W-1:0]        fillVpn,
  input  logic [PFN_W-1:0]        fillPfn,
  input  logic                    flush,
  output logic                    hit,
  output logic [PFN_W-1:0]        pfn,
  output logic [PFN_W+OFF_W-1:0]  physAddr,
  output logic                    hitRef,
  output logic                    hitDirty
);

  xlateStrobe_t       strobe;
  logic [ENTRIES-1:0] fillSel;
  logic [ENTRIES-1:0] lkMatch;
  logic [ENTRIES-1:0] fillMatch;
  logic [ENTRIES-1:0] validVec;
  logic [PFN_W-1:0]   selPfn;
  logic               selRef;
  logic               selDirty;

  xlate_ctrl #(.N(ENTRIES)) uCtrl (
    .clk       (clk),
    .rstN      (rstN),
    .lkValid   (lkValid),
    .lkWrite   (lkWrite),
    .fillValid (fillValid),
    .flush     (flush),
    .lkMatch   (lkMatch),
    .fillMatch (fillMatch),
    .validVec  (validVec),
    .strobe    (strobe),
    .fillSel   (fillSel),
    .hit       (hit)
  );

  xlate_datapath #(.N(ENTRIES), .VPN_W(VPN_W), .PFN_W(PFN_W)) uData (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .fillSel   (fillSel),
    .lkVpn     (lkVpn),
    .fillVpn   (fillVpn),
    .fillPfn   (fillPfn),
    .lkMatch   (lkMatch),
    .fillMatch (fillMatch),
    .validVec  (validVec),
    .selPfn    (selPfn),
    .selRef    (selRef),
    .selDirty  (selDirty)
  );

  assign pfn      = hit ? selPfn : '0;
  assign physAddr = hit ? {selPfn, lkOffset} : '0;
  assign hitRef   = hit && selRef;
  assign hitDirty = hit && selDirty;

endmodule

// File: rtl/xlate_cache_chk.sv
module xlate_cache_chk #(
  parameter int unsigned N     = 8,
  parameter int unsigned VPN_W = 20,
  parameter int unsigned PFN_W = 20
) (
  input logic             clk,
  input logic             rstN,
  input logic             lkValid,
  input logic             lkWrite,
  input logic [VPN_W-1:0] lkVpn,
  input logic             fillValid,
  input logic [VPN_W-1:0] fillVpn,
  input logic             flush,
  input logic             hit,
  input logic [PFN_W-1:0] pfn,
  input logic             hitRef,
  input logic             hitDirty,
  input logic [N-1:0]     lkMatch
);

  // R8: a page never matches two entries
  a_r8_single_match: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(lkMatch));

  // R3: a miss drives all result outputs low
  a_r3_miss_quiet: assert property (@(posedge clk) disable iff (!rstN)
    !hit |-> (pfn == '0 && !hitRef && !hitDirty));

  // R9: after a flush nothing hits
  a_r9_flush_empties: assert property (@(posedge clk) disable iff (!rstN)
    flush |=> !hit);

  // R2: a page just installed is found on the next lookup
  a_r2_fill_visible: assert property (@(posedge clk) disable iff (!rstN)
    (lkValid && $past(fillValid && !flush) && lkVpn == $past(fillVpn)) |-> hit);

  // R4: a repeated hit sees the reference bit set
  a_r4_ref_sticky: assert property (@(posedge clk) disable iff (!rstN)
    (hit && $past(hit && !flush && !fillValid) && lkVpn == $past(lkVpn)) |-> hitRef);

  // R5: a hit after a write hit to the same page sees it dirty
  a_r5_dirty_set: assert property (@(posedge clk) disable iff (!rstN)
    (hit && $past(hit && lkWrite && !flush && !fillValid) && lkVpn == $past(lkVpn))
      |-> hitDirty);

endmodule

bind xlate_cache xlate_cache_chk #(.N(ENTRIES), .VPN_W(VPN_W), .PFN_W(PFN_W)) uChk (
  .clk       (clk),
  .rstN      (rstN),
  .lkValid   (lkValid),
  .lkWrite   (lkWrite),
  .lkVpn     (lkVpn),
  .fillValid (fillValid),
  .fillVpn   (fillVpn),
  .flush     (flush),
  .hit       (hit),
  .pfn       (pfn),
  .hitRef    (hitRef),
  .hitDirty  (hitDirty),
  .lkMatch   (lkMatch)
);

// File: tb/sim_xlate_cache.sv
`timescale 1ns/1ps
module sim_xlate_cache;

  localparam int NE = 8;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        lkValid = 1'b0;
  logic        lkWrite = 1'b0;
  logic [19:0] lkVpn = '0;
  logic [11:0] lkOffset = '0;
  logic        fillValid = 1'b0;
  logic [19:0] fillVpn = '0;
  logic [19:0] fillPfn = '0;
  logic        flush = 1'b0;
  logic        hit;
  logic [19:0] pfn;
  logic [31:0] physAddr;
  logic        hitRef;
  logic        hitDirty;

  always #4 clk = ~clk;  // 125 MHz

  xlate_cache u0 (
    .clk(clk), .rstN(rstN), .lkValid(lkValid), .lkWrite(lkWrite),
    .lkVpn(lkVpn), .lkOffset(lkOffset), .fillValid(fillValid),
    .fillVpn(fillVpn), .fillPfn(fillPfn), .flush(flush),
    .hit(hit), .pfn(pfn), .physAddr(physAddr),
    .hitRef(hitRef), .hitDirty(hitDirty)
  );

  int compared = 0;
  int mismatched = 0;
  bit finished = 1'b0;

  // Scoreboard: {hit, pfn, physAddr, ref, dirty}
  logic [54:0] expQ[$];
  string       tagQ[$];

  // Reference model of the requirements
  logic [19:0] mVpn   [NE];
  logic [19:0] mPfn   [NE];
  logic        mValid [NE];
  logic        mRef   [NE];
  logic        mDirty [NE];
  int          mRr;

  function automatic logic [19:0] vp(input int i);
    return 20'h10000 + 20'(i) * 20'h00111;
  endfunction

  function automatic logic [19:0] pf(input int i);
    return 20'hA0000 + 20'(i) * 20'h00013;
  endfunction

  task automatic modelReset();
    for (int i = 0; i < NE; i++) begin
      mValid[i] = 1'b0; mRef[i] = 1'b0; mDirty[i] = 1'b0;
      mVpn[i] = '0; mPfn[i] = '0;
    end
    mRr = 0;
  endtask

  task automatic step(input logic lk, input logic wr, input logic [19:0] v,
                      input logic [11:0] off, input logic fv,
                      input logic [19:0] fvpn, input logic [19:0] fpfn,
                      input logic fl, input string tag);
    int hi;
    int tgt;
    logic [54:0] e;
    @(negedge clk);
    lkValid = lk; lkWrite = wr; lkVpn = v; lkOffset = off;
    fillValid = fv; fillVpn = fvpn; fillPfn = fpfn; flush = fl;
    hi = -1;
    for (int i = 0; i < NE; i++) if (mValid[i] && mVpn[i] == v) hi = i;
    if (lk) begin
      if (hi >= 0) e = {1'b1, mPfn[hi], mPfn[hi], off, mRef[hi], mDirty[hi]};
      else         e = '0;
      expQ.push_back(e);
      tagQ.push_back(tag);
    end
    // state after the coming edge
    if (fl) begin
      for (int i = 0; i < NE; i++) mValid[i] = 1'b0;
    end else begin
      if (lk && hi >= 0) begin
        mRef[hi] = 1'b1;
        if (wr) mDirty[hi] = 1'b1;
      end
      if (fv) begin
        tgt = -1;
        for (int i = 0; i < NE; i++) if (mValid[i] && mVpn[i] == fvpn) tgt = i;
        if (tgt < 0)
          for (int i = NE - 1; i >= 0; i--) if (!mValid[i]) tgt = i;
        if (tgt < 0) begin
          tgt = mRr;
          mRr = (mRr + 1) % NE;
        end
        mValid[tgt] = 1'b1; mVpn[tgt] = fvpn; mPfn[tgt] = fpfn;
        mRef[tgt] = 1'b0; mDirty[tgt] = 1'b0;
      end
    end
  endtask

  task automatic look(input logic wr, input int i, input string tag);
    step(1'b1, wr, vp(i), 12'(i * 16 + 3), 1'b0, '0, '0, 1'b0, tag);
  endtask

  task automatic fill(input int i, input logic [19:0] frame, input string tag);
    step(1'b0, 1'b0, '0, '0, 1'b1, vp(i), frame, 1'b0, tag);
  endtask

  // Monitor: compare the combinational result before the next edge
  initial begin
    forever begin
      @(negedge clk);
      #2;
      if (rstN && lkValid) begin
        logic [54:0] got;
        logic [54:0] e;
        string t;
        got = {hit, pfn, physAddr, hitRef, hitDirty};
        compared++;
        if (expQ.size() == 0) begin
          mismatched++;
          $display("FAIL scoreboard: result with no expected item, got %h", got);
        end else begin
          e = expQ.pop_front();
          t = tagQ.pop_front();
          if (got !== e) begin
            mismatched++;
            $display("FAIL %s: got hit=%b pfn=%h pa=%h ref=%b dirty=%b, expected hit=%b pfn=%h pa=%h ref=%b dirty=%b",
                     t, got[54], got[53:34], got[33:2], got[1], got[0],
                     e[54], e[53:34], e[33:2], e[1], e[0]);
          end
        end
      end
    end
  end

  // Watchdog
  initial begin
    #(8 * 50000);
    if (!finished) begin
      mismatched++;
      $display("FAIL watchdog: run did not complete, got hung, expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    modelReset();
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;

    // R1: empty after reset
    look(1'b0, 0, "R1 reset miss");
    look(1'b0, 7, "R1 reset miss");

    // R11: lookup and fill of the same page in one cycle misses
    step(1'b1, 1'b0, vp(0), 12'h003, 1'b1, vp(0), pf(0), 1'b0, "R11 same-cycle fill");
    for (int i = 1; i < NE; i++) fill(i, pf(i), "R6 fill");

    // R2, R4: all pages hit, reference clear on first touch
    for (int i = 0; i < NE; i++) look(1'b0, i, "R2 hit frame and address");
    look(1'b0, 3, "R4 reference set");

    // R5: write marks dirty, read does not
    look(1'b1, 5, "R5 write hit");
    look(1'b0, 5, "R5 dirty after write");
    look(1'b0, 6, "R5 read leaves clean");

    // R3: unknown page misses
    look(1'b0, 20, "R3 miss zero");
    step(1'b0, 1'b0, vp(3), 12'hFFF, 1'b0, '0, '0, 1'b0, "R3 idle");

    // R7: full, pointer at entry 0
    fill(8, pf(8), "R7 replace");
    look(1'b0, 0, "R7 victim evicted");
    look(1'b0, 8, "R7 new page present");
    look(1'b0, 1, "R7 neighbour kept");

    // R8: refill of a held page rewrites in place
    fill(3, 20'hBBBBB, "R8 refill");
    look(1'b0, 3, "R8 new frame, status cleared");
    fill(9, pf(9), "R8 pointer unchanged");
    look(1'b0, 1, "R8 pointer moved to entry 1 only");
    look(1'b0, 2, "R8 entry 2 kept");
    look(1'b0, 9, "R8 new page present");

    // R11: fill hits the entry that the lookup hits
    step(1'b1, 1'b1, vp(2), 12'h123, 1'b1, vp(2), 20'hCCCCC, 1'b0, "R11 lookup sees old");
    look(1'b0, 2, "R11 fill wins over status");

    // R9: flush
    step(1'b0, 1'b0, '0, '0, 1'b0, '0, '0, 1'b1, "R9 flush");
    look(1'b0, 8, "R9 flushed miss");
    look(1'b0, 3, "R9 flushed miss");

    // R10: flush and fill together
    step(1'b0, 1'b0, '0, '0, 1'b1, vp(10), pf(10), 1'b1, "R10 flush wins");
    look(1'b0, 10, "R10 fill dropped");

    // R6: refill all entries, nothing displaced while room remains
    for (int i = 11; i < 11 + NE; i++) fill(i, pf(i), "R6 fill");
    for (int i = 11; i < 11 + NE; i++) look(1'b0, i, "R6 all kept");

    // R9: pointer kept across flush (now at entry 2)
    fill(19, pf(19), "R9 pointer kept");
    look(1'b0, 13, "R9 entry 2 replaced");
    look(1'b0, 12, "R9 entry 1 kept");
    look(1'b0, 14, "R9 entry 3 kept");
    look(1'b0, 19, "R9 new page present");

    step(1'b0, 1'b0, '0, '0, 1'b0, '0, '0, 1'b0, "idle");
    @(negedge clk);
    #3;
    if (expQ.size() != 0) begin
      mismatched++;
      $display("FAIL scoreboard: %0d results missing, expected 0", expQ.size());
    end
    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule